// File: doc/BRIEF.md
# Dual-Channel Edge Capture Timer

This block timestamps transitions on two asynchronous input pins, called A and B, against one shared free-running 12-bit counter. The counter advances once every `TICK_DIV` system clocks. With a 6 MHz clock and the default divider of 6, one count is 1 µs. Each pin has a capture register for rising edges and another for falling edges, which gives four 8-bit registers in total.

A 3-bit scale code selects which 8-bit window of the counter is stored. Wider shifts trade resolution for range: the step can be 1, 2, 4, 8 or 16 counts, and the range runs from 256 counts up to 4096 counts. A single hold setting covers all four registers. When hold is off, every edge overwrites its register. When hold is on, a register keeps its first edge until software reads it.

Each capture register has its own interrupt enable. The two registers of a pin feed one shared pending flag, and that flag reaches its output only while the master capture enable is set. Software uses a simple single-cycle register port: a strobed write, and a combinational read whose strobe causes the read side effects.

Top module: `edge_cap_timer`

## Requirements
- R1: After a synchronous reset, all four capture registers, the configuration register (address 4) and the master enable (address 5) read as 0, and `irq_a` and `irq_b` are low.
- R2: The four capture registers sit at fixed addresses: 0 holds rising edges on A, 1 holds falling edges on A, 2 holds rising edges on B and 3 holds falling edges on B. An edge on one pin or direction leaves the other three registers unchanged.
- R3: The counter starts at 0 after reset and advances by one every `TICK_DIV` clocks. Each pin passes through a two-flop synchronizer. A capture register loads on the third rising clock after a pin change, and it takes the counter value present just before that clock.
- R4: Scale codes 0 to 4 store counter bits [7+k : k] for code k.
- R5: Scale codes 5, 6 and 7 behave exactly like code 4 (counter bits 11:4).
- R6: With hold off (config bit 7 = 0), each new edge overwrites its register, so a read returns the latest edge.
- R7: With hold on (config bit 7 = 1), a loaded register ignores later edges until it is read at its address. The read re-arms it, and the next edge loads again.
- R8: A pin's pending flag is set when one of its two registers loads and that register's enable bit is set. The enable bits are config bit 0 for A-rise, bit 1 for A-fall, bit 2 for B-rise and bit 3 for B-fall. `irq_a` and `irq_b` equal the pending flag ANDed with the master enable (address 5 bit 0).
- R9: Reading either capture register of a pin clears that pin's pending flag. A load in the same cycle keeps the flag set.
- R10: The configuration register at address 4 holds hold in bit 7, the scale code in bits 6:4 and the enables in bits 3:0, and it reads back as written. Writes to addresses 0 to 3 have no effect.
- R11: The 12-bit counter wraps from 4095 to 0 without any indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_a | input | 1 | Asynchronous input A |
| pin_b | input | 1 | Asynchronous input B |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_a | output | 1 | Capture interrupt for pin A |
| irq_b | output | 1 | Capture interrupt for pin B |

## Verification
On every cycle, the assertions check four things. The counter steps by exactly one on a tick and holds otherwise, wrap included. A held, unread register never changes. An interrupt is never raised while the master enable is off. A read of a pin's capture register with no concurrent load drops that pin's request.

The directed scenarios cover what needs a reference timeline. They compare the stored stamps against an independently kept count, which covers every scale code, the reserved codes, the synchronizer latency, overwrite versus hold, and the counter wrap. They also cover the sharing of each interrupt line between the rise and fall events of its pin.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

    localparam int CNT_W     = 12;
    localparam int CAP_W     = 8;
    localparam int PS_W      = 3;
    localparam int NUM_PINS  = 2;
    localparam int NUM_SLOTS = 2 * NUM_PINS;
    localparam int MAX_SHIFT = CNT_W - CAP_W;

    typedef enum logic [2:0] {
        REG_A_RISE = 3'd0,
        REG_A_FALL = 3'd1,
        REG_B_RISE = 3'd2,
        REG_B_FALL = 3'd3,
        REG_CFG    = 3'd4,
        REG_CTL    = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic                 hold;
        logic [PS_W-1:0]      scale;
        logic [NUM_SLOTS-1:0] irq_en;
    } cfg_t;

    function automatic logic [CAP_W-1:0] pick_slice(
        input logic [CNT_W-1:0] cnt,
        input logic [PS_W-1:0]  code
    );
        int sh;
        sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
        return CAP_W'(cnt >> sh);
    endfunction

endpackage

// File: rtl/ecap_timebase.sv
module ecap_timebase
    import ecap_pkg::*;
#(
    parameter int TICK_DIV = 6,
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PS_W-1:0]  scale,
    output logic             tick,
    output logic [CNT_W-1:0] count,
    output logic [CAP_W-1:0] stamp
);

    logic [DIV_W-1:0] div_q;

    assign tick = (div_q == DIV_W'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            count <= '0;
        end else if (tick) begin
            div_q <= '0;
            count <= count + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign stamp = pick_slice(count, scale);

endmodule

// File: rtl/ecap_edge_sync.sv
module ecap_edge_sync #(
    parameter int PINS   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pins,
    output logic [PINS-1:0] rise,
    output logic [PINS-1:0] fall
);

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        logic [STAGES-1:0] sh_q;
        logic              last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q   <= '0;
                last_q <= 1'b0;
            end else begin
                sh_q   <= {sh_q[STAGES-2:0], pins[g]};
                last_q <= sh_q[STAGES-1];
            end
        end

        assign rise[g] =  sh_q[STAGES-1] & ~last_q;
        assign fall[g] = ~sh_q[STAGES-1] &  last_q;
    end

endmodule

// File: rtl/ecap_slot.sv
module ecap_slot
    import ecap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic             edge_hit,
    input  logic             rd_hit,
    input  logic [CAP_W-1:0] stamp,
    output logic [CAP_W-1:0] value,
    output logic             full,
    output logic             loaded
);

    // A read in the same cycle re-arms the slot, so that edge is accepted.
    assign loaded = edge_hit && (!hold || !full || rd_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            full  <= 1'b0;
        end else begin
            if (loaded) value <= stamp;
            if (loaded)      full <= 1'b1;
            else if (rd_hit) full <= 1'b0;
        end
    end

endmodule

// File: rtl/edge_cap_timer.sv
module edge_cap_timer
    import ecap_pkg::*;
#(
    parameter int TICK_DIV    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_a,
    input  logic       pin_b,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_a,
    output logic       irq_b
);

    cfg_t                                cfg_q;
    logic                                master_q;
    logic                                tick;
    logic [CNT_W-1:0]                    count;
    logic [CAP_W-1:0]                    stamp;
    logic [NUM_PINS-1:0]                 rise;
    logic [NUM_PINS-1:0]                 fall;
    logic [NUM_SLOTS-1:0]                slot_full;
    logic [NUM_SLOTS-1:0]                slot_loaded;
    logic [NUM_SLOTS-1:0]                slot_rd;
    logic [NUM_SLOTS-1:0][CAP_W-1:0]     cap_q;
    logic [NUM_PINS-1:0]                 pend_q;
    logic [NUM_PINS-1:0]                 irq_vec;

    ecap_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
        .clk   (clk),
        .rst   (rst),
        .scale (cfg_q.scale),
        .tick  (tick),
        .count (count),
        .stamp (stamp)
    );

    ecap_edge_sync #(.PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pins ({pin_b, pin_a}),
        .rise (rise),
        .fall (fall)
    );

    // Slot 2p is the rising register of pin p, slot 2p+1 the falling one.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int PIN = s / 2;
        localparam bit IS_FALL = (s % 2) == 1;
        logic hit;

        assign hit        = IS_FALL ? fall[PIN] : rise[PIN];
        assign slot_rd[s] = rd_en && (addr == 3'(s));

        ecap_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .hold     (cfg_q.hold),
            .edge_hit (hit),
            .rd_hit   (slot_rd[s]),
            .stamp    (stamp),
            .value    (cap_q[s]),
            .full     (slot_full[s]),
            .loaded   (slot_loaded[s])
        );
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pend
        logic set_p;
        logic clr_p;

        assign set_p = (slot_loaded[2*p]   & cfg_q.irq_en[2*p]) |
                       (slot_loaded[2*p+1] & cfg_q.irq_en[2*p+1]);
        assign clr_p = slot_rd[2*p] | slot_rd[2*p+1];

        always_ff @(posedge clk) begin
            if (rst)        pend_q[p] <= 1'b0;
            else if (set_p) pend_q[p] <= 1'b1;
            else if (clr_p) pend_q[p] <= 1'b0;
        end

        assign irq_vec[p] = pend_q[p] & master_q;
    end

    assign irq_a = irq_vec[0];
    assign irq_b = irq_vec[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            master_q <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                REG_CFG: cfg_q    <= cfg_t'(wdata);
                REG_CTL: master_q <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            REG_A_RISE: rdata = cap_q[0];
            REG_A_FALL: rdata = cap_q[1];
            REG_B_RISE: rdata = cap_q[2];
            REG_B_FALL: rdata = cap_q[3];
            REG_CFG:    rdata = cfg_q;
            REG_CTL:    rdata = {7'd0, master_q};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecap_checker.sv
module ecap_checker
    import ecap_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            rd_en,
    input logic [2:0]                      addr,
    input logic                            irq_a,
    input logic                            irq_b,
    input logic                            master,
    input logic                            hold,
    input logic                            tick,
    input logic [CNT_W-1:0]                count,
    input logic [NUM_SLOTS-1:0]            full,
    input logic [NUM_SLOTS-1:0]            loaded,
    input logic [NUM_SLOTS-1:0][CAP_W-1:0] cap
);

    AST_IRQ_A_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_a |-> master); // R8
    AST_IRQ_B_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_b |-> master); // R8
    AST_IRQ_A_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr <= 3'd1 && !loaded[0] && !loaded[1]) |=> !irq_a); // R9
    AST_IRQ_B_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == 3'd2 || addr == 3'd3) && !loaded[2] && !loaded[3]) |=> !irq_b); // R9
    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == CNT_W'($past(count) + 1'b1)); // R11
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count)); // R3

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hold
        AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
            (hold && full[i] && !(rd_en && addr == 3'(i))) |=> $stable(cap[i])); // R7
    end

endmodule

bind edge_cap_timer ecap_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .irq_a  (irq_a),
    .irq_b  (irq_b),
    .master (master_q),
    .hold   (cfg_q.hold),
    .tick   (tick),
    .count  (count),
    .full   (slot_full),
    .loaded (slot_loaded),
    .cap    (cap_q)
);

// File: tb/edge_cap_timer_tb.sv
module edge_cap_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_a = 1'b0;
    logic       pin_b = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_a;
    logic       irq_b;

    int checks = 0;
    int fails  = 0;

    edge_cap_timer #(.TICK_DIV(TICK_DIV)) u_dut (
        .clk(clk), .rst(rst), .pin_a(pin_a), .pin_b(pin_b),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_a(irq_a), .irq_b(irq_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference count kept from the requirements (R3, R11).
    logic [11:0] mcnt;
    int          mdiv;
    always @(posedge clk) begin
        if (rst) begin
            mdiv <= 0;
            mcnt <= '0;
        end else if (mdiv == TICK_DIV - 1) begin
            mdiv <= 0;
            mcnt <= mcnt + 12'd1;
        end else begin
            mdiv <= mdiv + 1;
        end
    end

    function automatic int exp_slice(input int cnt, input int code);
        int sh;
        sh = (code > 4) ? 4 : code;
        return (cnt >> sh) & 8'hFF;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr  = 3'(a);
        wdata = 8'(d);
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr  = 3'(a);
        rd_en = 1'b1;
        #1 d = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Drives a pin and returns the count the register should stamp (R3).
    task automatic pin_edge(input int pin, input logic val, output int cnt);
        @(negedge clk);
        if (pin == 0) pin_a = val; else pin_b = val;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        cnt = int'(mcnt);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        int d;
        for (int a = 0; a < 6; a++) begin
            rd(a, d);
            check("R1", $sformatf("reset value addr %0d", a), d, 0);
        end
        check("R1", "irq_a after reset", int'(irq_a), 0);
        check("R1", "irq_b after reset", int'(irq_b), 0);
    endtask

    task automatic t_cfg();
        int d;
        wr(4, 8'h5A);
        rd(4, d);
        check("R10", "config readback", d, 8'h5A);
        wr(5, 8'h01);
        rd(5, d);
        check("R10", "master readback", d, 1);
        wr(0, 8'h77);
        rd(0, d);
        check("R10", "write to capture addr ignored", d, 0);
        wr(4, 0);
        wr(5, 0);
    endtask

    task automatic t_scale();
        int c, d;
        for (int code = 0; code < 8; code++) begin
            wr(4, code << 4);
            idle(code * 37 + 500);
            pin_edge(0, 1'b1, c);
            rd(0, d);
            check(code < 5 ? "R4" : "R5", $sformatf("A-rise scale %0d", code), d, exp_slice(c, code));
            idle(23);
            pin_edge(0, 1'b0, c);
            rd(1, d);
            check(code < 5 ? "R4" : "R5", $sformatf("A-fall scale %0d", code), d, exp_slice(c, code));
        end
        wr(4, 0);
    endtask

    task automatic t_four();
        int ra, c, d;
        rd(0, ra);
        idle(40);
        pin_edge(1, 1'b1, c);
        rd(2, d);
        check("R2", "B-rise register", d, exp_slice(c, 0));
        idle(40);
        pin_edge(1, 1'b0, c);
        rd(3, d);
        check("R2", "B-fall register", d, exp_slice(c, 0));
        rd(0, d);
        check("R2", "A-rise untouched by B edges", d, ra);
    endtask

    task automatic t_overwrite();
        int c1, c2, d;
        pin_edge(0, 1'b1, c1);
        idle(30);
        pin_edge(0, 1'b0, c1);
        idle(30);
        pin_edge(0, 1'b1, c2);
        rd(0, d);
        check("R6", "latest edge kept", d, exp_slice(c2, 0));
        pin_edge(0, 1'b0, c2);
    endtask

    task automatic t_hold();
        int c1, c2, c3, d;
        wr(4, 8'h80);
        for (int a = 0; a < 4; a++) rd(a, d);
        pin_edge(0, 1'b1, c1);
        idle(20);
        pin_edge(0, 1'b0, c2);
        idle(20);
        pin_edge(0, 1'b1, c2);
        rd(0, d);
        check("R7", "first edge held", d, exp_slice(c1, 0));
        idle(20);
        pin_edge(0, 1'b0, c2);
        idle(20);
        pin_edge(0, 1'b1, c3);
        rd(0, d);
        check("R7", "re-armed after read", d, exp_slice(c3, 0));
        pin_edge(0, 1'b0, c3);
        wr(4, 0);
        for (int a = 0; a < 4; a++) rd(a, d);
    endtask

    task automatic t_irq();
        int c, d;
        wr(4, 8'h01);
        wr(5, 0);
        pin_edge(0, 1'b1, c);
        check("R8", "irq_a masked by master", int'(irq_a), 0);
        wr(5, 1);
        check("R8", "irq_a after master on", int'(irq_a), 1);
        rd(1, d);
        check("R9", "irq_a cleared by A-fall read", int'(irq_a), 0);
        pin_edge(0, 1'b0, c);
        check("R8", "A-fall disabled no irq", int'(irq_a), 0);
        wr(4, 8'h08);
        pin_edge(1, 1'b1, c);
        check("R8", "B-rise disabled no irq", int'(irq_b), 0);
        pin_edge(1, 1'b0, c);
        check("R8", "irq_b on B-fall", int'(irq_b), 1);
        check("R8", "irq_a stays low", int'(irq_a), 0);
        rd(3, d);
        check("R9", "irq_b cleared by read", int'(irq_b), 0);
        wr(4, 8'h02);
        pin_edge(0, 1'b1, c);
        check("R8", "A-rise disabled no irq", int'(irq_a), 0);
        pin_edge(0, 1'b0, c);
        check("R8", "shared A line on fall", int'(irq_a), 1);
        rd(0, d);
        check("R9", "irq_a cleared by A-rise read", int'(irq_a), 0);
        wr(5, 0);
        wr(4, 0);
    endtask

    task automatic t_wrap();
        int c, d;
        wr(4, 8'h40);
        while (mcnt != 12'hFFF) @(posedge clk);
        while (mcnt != 12'h000) @(posedge clk);
        pin_edge(0, 1'b1, c);
        rd(0, d);
        check("R11", "stamp after wrap", d, exp_slice(c, 4));
        check("R11", "reference wrapped low", int'(c < 16), 1);
        pin_edge(0, 1'b0, c);
        wr(4, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cfg();
        t_scale();
        t_four();
        t_overwrite();
        t_hold();
        t_irq();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule